// File: doc/BRIEF.md
# Parallel ROM Read Controller

This block sits on the host side of a bank of asynchronous read-only memories that share one address bus and one data bus. A host hands it a byte address with a valid/ready request. The controller places the low address bits on the shared bus and pulls low the chip enable of the single device named by the upper address bits. It then lowers the common output-enable strobe later, at the point where both access paths finish together. It counts out the access time, registers the data bus and returns the byte with a one-cycle valid pulse.

The enable and strobe are released in the same edge that captures the data, so the address never moves while data is still needed. The controller then holds off the next access for the bus float time, so one device has stopped driving before another is selected. Every delay is given in nanoseconds together with the clock period. The controller turns each one into whole cycles by rounding up.

Top module: `rom_rd_ctrl`

## Requirements
- R1: While reset is held and right after it is released, every chip enable and the output enable are high (inactive), `rsp_valid` is low and `req_ready` is high.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both high. From that edge on, `mem_addr` carries `req_addr[DEV_AW-1:0]`, and only `mem_ce_n[k]` is low, where k is `req_addr[ADDR_W-1:DEV_AW]`.
- R3: `mem_oe_n` falls exactly LEAD cycles after the chip enable falls. Take CA, CE and CO as the address, enable and strobe access times divided by the clock period and rounded up. LEAD is max(CA,CE) minus CO, or 0 when that is negative.
- R4: The data bus is registered at the edge TOTAL cycles after the chip enable fell, with TOTAL = max(CA, CE, LEAD+CO). This is never before both access limits have elapsed. `rsp_data` then shows that byte while `rsp_valid` is high for exactly one cycle.
- R5: The address and the chip enables do not change while a chip enable is low.
- R6: All chip enables and the output enable go high in the same edge that raises `rsp_valid`.
- R7: No chip enable falls sooner than CF cycles after the last release, where CF is the float time divided by the period and rounded up.
- R8: `req_ready` is low during an access and its float gap. A request raised in that time is not taken and causes no bus access.
- R9: At most one chip enable is low at any time, and the output enable is low only while a chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_addr | input | ADDR_W | Byte address; the upper bits pick the device |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds the read byte |
| rsp_data | output | DW | Captured byte |
| mem_addr | output | DEV_AW | Shared address bus to the devices |
| mem_ce_n | output | N_DEV | Per-device chip enables, active low |
| mem_oe_n | output | 1 | Shared output-enable strobe, active low |
| mem_data | input | DW | Shared data bus from the devices |

## Verification
The bench builds the controller with a 20 ns period, 250 ns address and enable access, 100 ns strobe access and 60 ns float time. This gives rounded-up counts of 13, 13, 5 and 3. The strobe therefore lags the enable by 8 cycles, and the 12.5-cycle access falls between two edges, which exercises the rounding. A timed memory model on the bench drives the complement of the correct byte until every access limit has passed. A capture one cycle early or a late strobe therefore shows up as wrong data. With four devices, every decoded enable gets used, and back-to-back reads plus a request raised while busy put the float gap and the busy interval under test.

// File: rtl/rom_rd_pkg.sv
`timescale 1ns/10ps
package rom_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_ACCESS  = 3'd2,
    ST_CAPTURE = 3'd3,
    ST_RELEASE = 3'd4
  } rd_state_e;

  // round a delay up to whole clock cycles
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rom_ce_decode.sv
`timescale 1ns/10ps
module rom_ce_decode #(
  parameter int unsigned N_DEV = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             enable,
  output logic [N_DEV-1:0] ce_n
);

  for (genvar i = 0; i < N_DEV; i++) begin : g_dev
    assign ce_n[i] = ~(enable && (sel == SEL_W'(i)));
  end

endmodule

// File: rtl/rom_rd_fsm.sv
`timescale 1ns/10ps
module rom_rd_fsm
  import rom_rd_pkg::*;
#(
  parameter int unsigned OE_LEAD   = 5,
  parameter int unsigned TOTAL     = 10,
  parameter int unsigned FLOAT_CYC = 3,
  parameter int unsigned CW        = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic load_req,
  output logic capture,
  output logic ce_on_d,
  output logic oe_on_d,
  output logic rsp_valid
);

  localparam logic [CW-1:0] LEAD_C  = CW'(OE_LEAD);
  localparam logic [CW-1:0] TOTAL_C = CW'(TOTAL);
  localparam logic [CW-1:0] FLT_C   = CW'(FLOAT_CYC);

  rd_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] elapsed;
  logic          cnt_en;
  logic          rsp_d;

  assign elapsed = cnt_q + 1'b1;
  assign cnt_en  = (state_q != ST_IDLE) || load_req;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = elapsed;
    req_ready = 1'b0;
    load_req  = 1'b0;
    capture   = 1'b0;
    rsp_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        cnt_d     = '0;
        if (req_valid) begin
          load_req = 1'b1;
          state_d  = (OE_LEAD == 0) ? ST_ACCESS : ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (elapsed >= LEAD_C) state_d = ST_ACCESS;
      end
      ST_ACCESS: begin
        if (elapsed >= TOTAL_C) begin
          capture = 1'b1;
          rsp_d   = 1'b1;
          cnt_d   = '0;
          state_d = ST_CAPTURE;
        end
      end
      ST_CAPTURE: begin
        state_d = (elapsed >= FLT_C) ? ST_IDLE : ST_RELEASE;
      end
      ST_RELEASE: begin
        if (elapsed >= FLT_C) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ce_on_d = (state_d == ST_SETUP) || (state_d == ST_ACCESS);
  assign oe_on_d = (state_d == ST_ACCESS);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= rsp_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // R4: a response lasts a single cycle
  p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/rom_rd_datapath.sv
`timescale 1ns/10ps
module rom_rd_datapath #(
  parameter int unsigned N_DEV  = 4,
  parameter int unsigned DEV_AW = 12,
  parameter int unsigned DW     = 8,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_req,
  input  logic                    capture,
  input  logic                    ce_on_d,
  input  logic                    oe_on_d,
  input  logic [DEV_AW+SEL_W-1:0] req_addr,
  input  logic [DW-1:0]           mem_data,
  output logic [DEV_AW-1:0]       mem_addr,
  output logic [N_DEV-1:0]        mem_ce_n,
  output logic                    mem_oe_n,
  output logic [DW-1:0]           rsp_data
);

  localparam int unsigned ADDR_W = DEV_AW + SEL_W;

  logic [SEL_W-1:0] sel_q, sel_d;
  logic [N_DEV-1:0] ce_n_d;

  assign sel_d = load_req ? req_addr[ADDR_W-1 -: SEL_W] : sel_q;

  rom_ce_decode #(.N_DEV(N_DEV), .SEL_W(SEL_W)) u_dec (
    .sel    (sel_d),
    .enable (ce_on_d),
    .ce_n   (ce_n_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      sel_q    <= '0;
      mem_ce_n <= '1;
      mem_oe_n <= 1'b1;
      rsp_data <= '0;
    end else begin
      if (load_req) begin
        mem_addr <= req_addr[DEV_AW-1:0];
        sel_q    <= sel_d;
      end
      mem_ce_n <= ce_n_d;
      mem_oe_n <= ~oe_on_d;
      if (capture) rsp_data <= mem_data;
    end
  end

  // R9: never two devices selected
  p_one_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_ce_n) <= 1);

  // R9: strobe only with a selected device
  p_oe_with_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_ce_n != '1));

  // R5: bus frozen during a selection
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_ce_n != '1) && ($past(mem_ce_n) != '1)) |-> ($stable(mem_addr) && $stable(mem_ce_n)));

endmodule

// File: rtl/rom_rd_ctrl.sv
`timescale 1ns/10ps
module rom_rd_ctrl
  import rom_rd_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_ADDR_NS     = 200,
  parameter int unsigned T_CE_NS       = 200,
  parameter int unsigned T_OE_NS       = 100,
  parameter int unsigned T_FLOAT_NS    = 60,
  parameter int unsigned N_DEV         = 4,
  parameter int unsigned DEV_AW        = 12,
  parameter int unsigned DW            = 8,
  localparam int unsigned SEL_W        = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int unsigned ADDR_W       = DEV_AW + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic [DEV_AW-1:0] mem_addr,
  output logic [N_DEV-1:0]  mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DW-1:0]     mem_data
);

  localparam int unsigned C_ADDR  = umax(ns_to_cycles(T_ADDR_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned C_CE    = umax(ns_to_cycles(T_CE_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned C_OE    = umax(ns_to_cycles(T_OE_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned C_FLT   = umax(ns_to_cycles(T_FLOAT_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned C_ACC   = umax(C_ADDR, C_CE);
  localparam int unsigned OE_LEAD = (C_ACC > C_OE) ? (C_ACC - C_OE) : 0;
  localparam int unsigned TOTAL   = umax(C_ACC, OE_LEAD + C_OE);
  localparam int unsigned CW      = $clog2(umax(TOTAL, C_FLT) + 2);

  logic load_req, capture, ce_on_d, oe_on_d;

  rom_rd_fsm #(
    .OE_LEAD   (OE_LEAD),
    .TOTAL     (TOTAL),
    .FLOAT_CYC (C_FLT),
    .CW        (CW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .load_req  (load_req),
    .capture   (capture),
    .ce_on_d   (ce_on_d),
    .oe_on_d   (oe_on_d),
    .rsp_valid (rsp_valid)
  );

  rom_rd_datapath #(
    .N_DEV  (N_DEV),
    .DEV_AW (DEV_AW),
    .DW     (DW),
    .SEL_W  (SEL_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_req (load_req),
    .capture  (capture),
    .ce_on_d  (ce_on_d),
    .oe_on_d  (oe_on_d),
    .req_addr (req_addr),
    .mem_data (mem_data),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .rsp_data (rsp_data)
  );

  // checker counters: cycles with a device selected, cycles with the bus idle
  logic [CW-1:0] sel_age_q, idle_age_q;
  logic          any_sel;
  assign any_sel = (mem_ce_n != '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_age_q  <= '0;
      idle_age_q <= CW'(C_FLT);
    end else begin
      if (any_sel) begin
        idle_age_q <= '0;
        if (sel_age_q != '1) sel_age_q <= sel_age_q + 1'b1;
      end else begin
        sel_age_q <= '0;
        if (idle_age_q != '1) idle_age_q <= idle_age_q + 1'b1;
      end
    end
  end

  // R3: strobe lags the enable by the computed lead
  p_oe_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (sel_age_q == CW'(OE_LEAD)));

  // R6: enables released together with the response
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!any_sel && mem_oe_n));

  // R7: float gap before a new selection
  p_float_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_sel) |-> (idle_age_q >= CW'(C_FLT)));

  // R8: not ready while a device is selected
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_sel |-> !req_ready);

endmodule

// File: tb/rom_rd_ctrl_tb.sv
`timescale 1ns/10ps
module rom_rd_ctrl_tb;

  localparam int unsigned CLK_NS = 20;
  localparam int unsigned TA = 250, TC = 250, TO = 100, TF = 60;
  // bench's own cycle arithmetic
  localparam int E_A     = (TA + CLK_NS - 1) / CLK_NS;
  localparam int E_C     = (TC + CLK_NS - 1) / CLK_NS;
  localparam int E_O     = (TO + CLK_NS - 1) / CLK_NS;
  localparam int E_F     = (TF + CLK_NS - 1) / CLK_NS;
  localparam int E_ACC   = (E_A > E_C) ? E_A : E_C;
  localparam int E_LEAD  = (E_ACC > E_O) ? E_ACC - E_O : 0;
  localparam int E_TOTAL = (E_ACC > E_LEAD + E_O) ? E_ACC : E_LEAD + E_O;

  logic        clk, rst_n, req_valid, req_ready, rsp_valid, mem_oe_n;
  logic [13:0] req_addr;
  logic [7:0]  rsp_data, mem_data;
  logic [11:0] mem_addr;
  logic [3:0]  mem_ce_n;

  rom_rd_ctrl #(
    .CLK_PERIOD_NS (CLK_NS), .T_ADDR_NS (TA), .T_CE_NS (TC),
    .T_OE_NS (TO), .T_FLOAT_NS (TF), .N_DEV (4), .DEV_AW (12), .DW (8)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_addr (req_addr),
    .req_ready (req_ready), .rsp_valid (rsp_valid), .rsp_data (rsp_data),
    .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n),
    .mem_data (mem_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, fails = 0;

  function automatic logic [7:0] pat(input logic [1:0] d, input logic [11:0] a);
    return {d, 6'b0} ^ a[7:0] ^ {a[11:8], 4'h0} ^ 8'h3C;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // ---------------- timed memory model ----------------
  realtime t_a = 0.0, t_c = 0.0, t_o = 0.0;
  always @(mem_addr) t_a = $realtime;
  always @(mem_ce_n) t_c = $realtime;
  always @(mem_oe_n) t_o = $realtime;

  initial begin
    mem_data = 8'h5A;
    #0.25;
    forever begin
      int nsel, dsel;
      realtime now;
      now = $realtime; nsel = 0; dsel = 0;
      for (int i = 0; i < 4; i++) if (!mem_ce_n[i]) begin nsel++; dsel = i; end
      if (nsel == 1 && !mem_oe_n) begin
        if ((now - t_a >= TA - 1) && (now - t_c >= TC - 1) && (now - t_o >= TO - 1))
          mem_data = pat(dsel[1:0], mem_addr);
        else
          mem_data = ~pat(dsel[1:0], mem_addr);
      end else begin
        mem_data = 8'h5A;
      end
      #1;
    end
  end

  // ---------------- monitor ----------------
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ce_fall_cyc, oe_fall_cyc, rsp_cyc, rel_cyc, last_gap;
  int n_access = 0, n_rsp = 0, stab_err = 0;
  bit have_rel = 0, rsp_bus_idle;
  logic [3:0]  ce_fall_val;
  logic [11:0] addr_at;
  logic [7:0]  rsp_val;
  logic [3:0]  ce_prev = 4'hF;
  logic        oe_prev = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      check(($countones(~mem_ce_n) <= 1) && (mem_oe_n || mem_ce_n != 4'hF),
            "R9", "selection", {mem_ce_n, 3'b0, mem_oe_n}, 0);
      if (mem_ce_n != 4'hF && ce_prev == 4'hF) begin
        ce_fall_cyc = cyc; ce_fall_val = mem_ce_n; addr_at = mem_addr; n_access++;
        if (have_rel) begin
          last_gap = cyc - rel_cyc;
          check(last_gap >= E_F, "R7", "float gap", last_gap, E_F);
        end
      end
      if (mem_ce_n != 4'hF && ce_prev != 4'hF && (mem_addr != addr_at || mem_ce_n != ce_fall_val))
        stab_err++;
      if (mem_ce_n == 4'hF && ce_prev != 4'hF) begin rel_cyc = cyc; have_rel = 1; end
      if (!mem_oe_n && oe_prev) oe_fall_cyc = cyc;
      if (rsp_valid) begin
        rsp_cyc = cyc; rsp_val = rsp_data; n_rsp++;
        rsp_bus_idle = (mem_ce_n == 4'hF) && mem_oe_n;
      end
    end
    ce_prev = mem_ce_n;
    oe_prev = mem_oe_n;
  end

  // ---------------- scenario tasks ----------------
  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wait_ready();
    tick();
    for (int k = 0; k < 100 && !req_ready; k++) tick();
  endtask

  task automatic wait_rsp(input int n0);
    for (int k = 0; k < 200 && n_rsp == n0; k++) tick();
  endtask

  task automatic do_read(input logic [13:0] a);
    int acc_c, n0;
    logic [3:0] exp_ce;
    wait_ready();
    n0 = n_rsp;
    req_addr = a; req_valid = 1'b1; acc_c = cyc + 1;
    tick();
    req_valid = 1'b0;
    wait_rsp(n0);
    exp_ce = ~(4'b0001 << a[13:12]);
    check(n_rsp == n0 + 1, "R4", "response seen", n_rsp, n0 + 1);
    check(ce_fall_cyc == acc_c, "R2", "enable cycle", ce_fall_cyc, acc_c);
    check(ce_fall_val == exp_ce, "R2", "enable decode", ce_fall_val, exp_ce);
    check(addr_at == a[11:0], "R2", "address bus", addr_at, a[11:0]);
    check(oe_fall_cyc - ce_fall_cyc == E_LEAD, "R3", "strobe lead", oe_fall_cyc - ce_fall_cyc, E_LEAD);
    check(rsp_cyc - ce_fall_cyc == E_TOTAL, "R4", "capture cycle", rsp_cyc - ce_fall_cyc, E_TOTAL);
    check((rsp_cyc - ce_fall_cyc >= E_ACC) && (rsp_cyc - oe_fall_cyc >= E_O), "R4",
          "capture not early", rsp_cyc - ce_fall_cyc, E_ACC);
    check(rsp_val == pat(a[13:12], a[11:0]), "R4", "data", rsp_val, pat(a[13:12], a[11:0]));
    check(rsp_bus_idle, "R6", "release with response", rsp_bus_idle, 1);
    check(rel_cyc == rsp_cyc, "R6", "release cycle", rel_cyc, rsp_cyc);
    check(stab_err == 0, "R5", "bus stable", stab_err, 0);
    tick();
    check(!rsp_valid, "R4", "single pulse", rsp_valid, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    repeat (3) tick();
    check(mem_ce_n == 4'hF && mem_oe_n && !rsp_valid && req_ready, "R1", "in reset",
          {mem_ce_n, mem_oe_n, rsp_valid, req_ready}, 8'h7D);
    @(negedge clk); rst_n = 1'b1;
    tick();
    check(mem_ce_n == 4'hF && mem_oe_n && !rsp_valid && req_ready, "R1", "after reset",
          {mem_ce_n, mem_oe_n, rsp_valid, req_ready}, 8'h7D);
  endtask

  task automatic t_single();
    do_read(14'h0005);
  endtask

  task automatic t_all_devices();
    do_read(14'h1ABC);
    do_read(14'h2FFF);
    do_read(14'h3000);
    do_read(14'h0A5A);
  endtask

  task automatic t_back_to_back();
    do_read(14'h2123);
    do_read(14'h1321);
    check(last_gap >= E_F, "R7", "gap back to back", last_gap, E_F);
  endtask

  task automatic t_busy_ignore();
    int n_acc0, n_rsp0;
    wait_ready();
    n_rsp0 = n_rsp;
    req_addr = 14'h3456; req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    n_acc0 = n_access;
    repeat (3) tick();
    req_addr = 14'h0777; req_valid = 1'b1;
    for (int k = 0; k < 2; k++) begin
      check(!req_ready, "R8", "ready low when busy", req_ready, 0);
      tick();
    end
    req_valid = 1'b0;
    wait_rsp(n_rsp0);
    check(rsp_val == pat(2'd3, 12'h456), "R8", "first request data", rsp_val, pat(2'd3, 12'h456));
    repeat (E_F + E_TOTAL + 4) tick();
    check(n_access == n_acc0, "R8", "no extra access", n_access, n_acc0);
    check(n_rsp == n_rsp0 + 1, "R8", "no extra response", n_rsp, n_rsp0 + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_single();
    t_all_devices();
    t_back_to_back();
    t_busy_ignore();
    repeat (3) tick();
    finish_run();
  end

endmodule